// File: doc/BRIEF.md
# Sub-word Register Access Adapter

This adapter sits between a host I/O port and three 32-bit register targets: a sixteen-word SCSI core window, an eight-word DMA window and one bus-control word. All of them live in a 128-byte little-endian I/O space. The host may read or write 1, 2, 3 or 4 bytes at any byte offset. The targets only take whole 32-bit words.

For a write, the adapter fetches the current word of the addressed region and replaces only the lanes the host supplied. It then issues one full-word write strobe at the aligned address. For a read, it shifts the selected word down by the byte offset and keeps only the requested number of bytes, right-aligned. Parts of the map are not backed by any register. Writes there are dropped, and reads there return zero.

The targets present their read data combinationally for the index the adapter drives. Every request is a single-cycle pulse. The result appears on the clock edge after the one that samples the request.

Top module: `subword_reg_adapter`

## Requirements
- R1: Byte addresses 0x00-0x3F map to the SCSI core window, at word index address[5:2].
- R2: Byte addresses 0x40-0x5F map to the DMA window, at word index (address - 0x40) >> 2. The index is driven on the same index pins.
- R3: A write whose word-aligned address is 0x70 updates the bus-control word. A write anywhere in 0x60-0x73 merges with the bus-control word. A read returns the bus-control word only when the byte address is exactly 0x70.
- R4: Writes whose aligned address is 0x60-0x6F or 0x74-0x7F produce no write strobe. Reads at 0x60-0x7F other than 0x70 return zero.
- R5: `host_size` encodes the byte count minus one (0 = 1 byte ... 3 = 4 bytes). Write byte k goes to lane (offset + k), where lane n is bits [8n+7:8n]. All other lanes keep the current value of the target word.
- R6: Write bytes that would land beyond lane 3 are discarded.
- R7: Read data equals the selected word shifted right by 8 x offset, masked to 8 x (size code + 1) bits. All higher bits are zero.
- R8: A write request gives exactly one cycle of one write strobe, carrying the merged data and word index, on the cycle after the request edge. A write never raises `host_ack`.
- R9: A read request raises `host_ack` for exactly one cycle, on the cycle after the request edge, with `host_rdata` valid. A read never raises a write strobe.
- R10: During reset and after its release with no request, `host_ack`, all write strobes and `host_rdata` are low.
- R11: At most one of the three write strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Single-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte address in the I/O space |
| host_size | input | 2 | Byte count minus one |
| host_wdata | input | 32 | Write bytes, right-aligned |
| host_ack | output | 1 | Read completion pulse |
| host_rdata | output | 32 | Right-aligned read data |
| tgt_index | output | 4 | Combinational word index for target read data |
| core_rdata | input | 32 | Current SCSI core word at tgt_index |
| dma_rdata | input | 32 | Current DMA word at tgt_index[2:0] |
| bctl_rdata | input | 32 | Current bus-control word |
| core_we | output | 1 | SCSI core full-word write strobe |
| dma_we | output | 1 | DMA full-word write strobe |
| bctl_we | output | 1 | Bus-control write strobe |
| wr_index | output | 4 | Word index of the strobed write |
| wr_data | output | 32 | Merged 32-bit write data |

## Verification
The hardest cases to reach are the ones where the write region and the read region disagree. One is an unaligned write at 0x71-0x73, which must still land on the bus-control word even though a read at that address returns zero. Another is a write near the top of the gap, which merges with the bus-control word yet must not strobe anything. A third is a write that spills past lane 3. The stimulus sweeps every byte address against every size code. After each write it reads back at the same address and size, so each combination of offset, size and region is checked against storage that has accumulated all earlier merges.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CORE = 2'd1,
    TGT_DMA  = 2'd2,
    TGT_BCTL = 2'd3
  } tgt_e;

  // Mask covering (code + 1) low bytes of a word.
  function automatic logic [31:0] size_mask(input logic [1:0] code);
    logic [31:0] m;
    case (code)
      2'd0:    m = 32'h0000_00FF;
      2'd1:    m = 32'h0000_FFFF;
      2'd2:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/swa_decode.sv
module swa_decode
  import swa_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int IDX_W     = 4,
  parameter int CORE_END  = 'h40,
  parameter int DMA_END   = 'h60,
  parameter int FETCH_END = 'h74,
  parameter int BCTL_ADDR = 'h70
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              fetch_tgt,
  output tgt_e              wr_tgt,
  output tgt_e              rd_tgt,
  output logic [IDX_W-1:0]  index
);
  localparam logic [ADDR_W-1:0] CORE_E  = ADDR_W'(CORE_END);
  localparam logic [ADDR_W-1:0] DMA_E   = ADDR_W'(DMA_END);
  localparam logic [ADDR_W-1:0] FETCH_E = ADDR_W'(FETCH_END);
  localparam logic [ADDR_W-1:0] BCTL_A  = ADDR_W'(BCTL_ADDR);

  logic [ADDR_W-1:0] aligned;

  always_comb begin
    aligned = {addr[ADDR_W-1:2], 2'b00};
    index   = addr[IDX_W+1:2];

    // region whose word is fetched for merging
    if (addr < CORE_E)       fetch_tgt = TGT_CORE;
    else if (addr < DMA_E)   fetch_tgt = TGT_DMA;
    else if (addr < FETCH_E) fetch_tgt = TGT_BCTL;
    else                     fetch_tgt = TGT_NONE;

    // region that receives the full-word write
    if (aligned < CORE_E)      wr_tgt = TGT_CORE;
    else if (aligned < DMA_E)  wr_tgt = TGT_DMA;
    else if (aligned == BCTL_A) wr_tgt = TGT_BCTL;
    else                       wr_tgt = TGT_NONE;

    // region returned by a read (exact byte address for bus-control)
    if (addr < CORE_E)       rd_tgt = TGT_CORE;
    else if (addr < DMA_E)   rd_tgt = TGT_DMA;
    else if (addr == BCTL_A) rd_tgt = TGT_BCTL;
    else                     rd_tgt = TGT_NONE;
  end
endmodule

// File: rtl/swa_merge.sv
module swa_merge #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] cur_word,
  input  logic [8*LANES-1:0] new_bytes,
  input  logic [1:0]         off,
  input  logic [1:0]         code,
  output logic [8*LANES-1:0] merged
);
  logic [8*LANES-1:0] shifted;
  assign shifted = new_bytes << {off, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       take;
    logic [2:0] rel;
    always_comb begin
      rel  = 3'(i) - {1'b0, off};
      take = (3'(i) >= {1'b0, off}) && (rel <= {1'b0, code});
      merged[8*i +: 8] = take ? shifted[8*i +: 8] : cur_word[8*i +: 8];
    end
  end
endmodule

// File: rtl/swa_rdalign.sv
module swa_rdalign
  import swa_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  off,
  input  logic [1:0]  code,
  output logic [31:0] data
);
  always_comb begin
    data = (word >> {off, 3'b000}) & size_mask(code);
  end
endmodule

// File: rtl/subword_reg_adapter.sv
module subword_reg_adapter
  import swa_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_ack,
  output logic [31:0]       host_rdata,
  output logic [IDX_W-1:0]  tgt_index,
  input  logic [31:0]       core_rdata,
  input  logic [31:0]       dma_rdata,
  input  logic [31:0]       bctl_rdata,
  output logic              core_we,
  output logic              dma_we,
  output logic              bctl_we,
  output logic [IDX_W-1:0]  wr_index,
  output logic [31:0]       wr_data
);
  tgt_e        fetch_tgt, wr_tgt, rd_tgt;
  logic [31:0] cur_word, rd_word, merged, aligned_rd;
  logic        wr_go, rd_go;

  logic              ack_q, ack_d;
  logic [31:0]       rdata_q, rdata_d;
  logic [2:0]        we_q, we_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [31:0]       wdat_q, wdat_d;

  swa_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr      (host_addr),
    .fetch_tgt (fetch_tgt),
    .wr_tgt    (wr_tgt),
    .rd_tgt    (rd_tgt),
    .index     (tgt_index)
  );

  always_comb begin
    case (fetch_tgt)
      TGT_CORE: cur_word = core_rdata;
      TGT_DMA:  cur_word = dma_rdata;
      TGT_BCTL: cur_word = bctl_rdata;
      default:  cur_word = '0;
    endcase
    case (rd_tgt)
      TGT_CORE: rd_word = core_rdata;
      TGT_DMA:  rd_word = dma_rdata;
      TGT_BCTL: rd_word = bctl_rdata;
      default:  rd_word = '0;
    endcase
  end

  swa_merge #(.LANES(4)) u_merge (
    .cur_word  (cur_word),
    .new_bytes (host_wdata),
    .off       (host_addr[1:0]),
    .code      (host_size),
    .merged    (merged)
  );

  swa_rdalign u_rdalign (
    .word (rd_word),
    .off  (host_addr[1:0]),
    .code (host_size),
    .data (aligned_rd)
  );

  // next-state
  always_comb begin
    wr_go   = host_req && host_we;
    rd_go   = host_req && !host_we;
    ack_d   = rd_go;
    rdata_d = rd_go ? aligned_rd : '0;
    we_d    = 3'b000;
    if (wr_go) begin
      case (wr_tgt)
        TGT_CORE: we_d = 3'b001;
        TGT_DMA:  we_d = 3'b010;
        TGT_BCTL: we_d = 3'b100;
        default:  we_d = 3'b000;
      endcase
    end
    idx_d  = wr_go ? tgt_index : idx_q;
    wdat_d = wr_go ? merged    : wdat_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      we_q    <= '0;
      idx_q   <= '0;
      wdat_q  <= '0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      we_q    <= we_d;
      idx_q   <= idx_d;
      wdat_q  <= wdat_d;
    end
  end

  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
  assign core_we    = we_q[0];
  assign dma_we     = we_q[1];
  assign bctl_we    = we_q[2];
  assign wr_index   = idx_q;
  assign wr_data    = wdat_q;

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_we, dma_we, bctl_we}));

  // R8
  strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we || dma_we || bctl_we) |-> ($past(host_req) && $past(host_we) && !host_ack));

  // R3
  bctl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bctl_we |-> ($past(host_addr[ADDR_W-1:2]) == 5'h1C));

  // R7
  rdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> ((host_rdata & ~size_mask($past(host_size))) == '0));

  // R4
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && $past(host_addr) >= 7'h60 && $past(host_addr) != 7'h70)
      |-> (host_rdata == '0));
endmodule

// File: tb/subword_reg_adapter_tb.sv
module subword_reg_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [6:0]  host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic [3:0]  tgt_index, wr_index;
  logic [31:0] core_rdata, dma_rdata, bctl_rdata, wr_data;
  logic        core_we, dma_we, bctl_we;

  logic [31:0] core_mem [16];
  logic [31:0] dma_mem  [8];
  logic [31:0] bctl_reg;
  logic [31:0] exp_core [16];
  logic [31:0] exp_dma  [8];
  logic [31:0] exp_bctl;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  subword_reg_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata), .tgt_index(tgt_index),
    .core_rdata(core_rdata), .dma_rdata(dma_rdata), .bctl_rdata(bctl_rdata),
    .core_we(core_we), .dma_we(dma_we), .bctl_we(bctl_we),
    .wr_index(wr_index), .wr_data(wr_data)
  );

  function automatic logic [31:0] seed_word(int i);
    return 32'hA5C3_0F10 ^ (32'h0101_0101 * (i + 1));
  endfunction

  // target storage, written only through the adapter strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_mem[i] <= seed_word(i);
      for (int i = 0; i < 8; i++)  dma_mem[i]  <= seed_word(i + 16);
      bctl_reg <= seed_word(24);
    end else begin
      if (core_we) core_mem[wr_index]      <= wr_data;
      if (dma_we)  dma_mem[wr_index[2:0]]  <= wr_data;
      if (bctl_we) bctl_reg                <= wr_data;
    end
  end

  assign core_rdata = core_mem[tgt_index];
  assign dma_rdata  = dma_mem[tgt_index[2:0]];
  assign bctl_rdata = bctl_reg;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] fetch_exp(int a);
    if (a < 'h40)      return exp_core[a >> 2];
    else if (a < 'h60) return exp_dma[(a - 'h40) >> 2];
    else if (a < 'h74) return exp_bctl;
    return 32'h0;
  endfunction

  function automatic logic [31:0] read_exp(int a, int sz);
    logic [31:0] w;
    logic [63:0] m;
    if (a < 'h40)       w = exp_core[a >> 2];
    else if (a < 'h60)  w = exp_dma[(a - 'h40) >> 2];
    else if (a == 'h70) w = exp_bctl;
    else                w = 32'h0;
    m = (64'h1 << (8 * (sz + 1))) - 64'h1;
    return 32'((64'(w) >> (8 * (a % 4))) & m);
  endfunction

  task automatic do_write(int a, int sz, logic [31:0] d);
    logic [63:0] m, mg;
    logic [31:0] merged;
    int al, sh;
    al = a & 'h7C;
    sh = 8 * (a % 4);
    m  = (64'h1 << (8 * (sz + 1))) - 64'h1;
    mg = (64'(fetch_exp(a)) & ~(m << sh)) | ((64'(d) & m) << sh);
    merged = mg[31:0];
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 7'(a);
    host_size = 2'(sz); host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    check(!host_ack, "R8 ack on write", {31'b0, host_ack}, 32'h0);
    if (al < 'h40) begin
      // R1 R5 R6
      check(core_we && !dma_we && !bctl_we && wr_index == 4'(al >> 2)
            && wr_data == merged, "R1/R5/R6 core write", wr_data, merged);
      exp_core[al >> 2] = merged;
    end else if (al < 'h60) begin
      // R2 R5 R6
      check(dma_we && !core_we && !bctl_we && wr_index[2:0] == 3'((al - 'h40) >> 2)
            && wr_data == merged, "R2/R5/R6 dma write", wr_data, merged);
      exp_dma[(al - 'h40) >> 2] = merged;
    end else if (al == 'h70) begin
      // R3
      check(bctl_we && !core_we && !dma_we && wr_data == merged,
            "R3 bctl write", wr_data, merged);
      exp_bctl = merged;
    end else begin
      // R4
      check(!core_we && !dma_we && !bctl_we, "R4 hole write strobe",
            {29'b0, bctl_we, dma_we, core_we}, 32'h0);
    end
    @(negedge clk);
    // R8 single-cycle strobe
    check(!core_we && !dma_we && !bctl_we, "R8 strobe width",
          {29'b0, bctl_we, dma_we, core_we}, 32'h0);
  endtask

  task automatic do_read(int a, int sz);
    logic [31:0] e;
    e = read_exp(a, sz);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 7'(a);
    host_size = 2'(sz); host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    host_req = 1'b0;
    // R7 R3 R4 R9
    check(host_ack && host_rdata == e, "R7/R9 read data", host_rdata, e);
    check(!core_we && !dma_we && !bctl_we, "R9 strobe on read",
          {29'b0, bctl_we, dma_we, core_we}, 32'h0);
    @(negedge clk);
    check(!host_ack, "R9 ack width", {31'b0, host_ack}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_core[i] = seed_word(i);
    for (int i = 0; i < 8; i++)  exp_dma[i]  = seed_word(i + 16);
    exp_bctl = seed_word(24);
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_size = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10
    check(!host_ack && !core_we && !dma_we && !bctl_we && host_rdata == 0,
          "R10 reset state", host_rdata, 32'h0);
    // full-word reads of the seeded contents first
    for (int a = 0; a < 128; a += 4) do_read(a, 3);
    // sweep every address and size: write then read back
    for (int a = 0; a < 128; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        do_write(a, sz, 32'h9E37_79B9 * (a * 4 + sz + 1));
        do_read(a, sz);
      end
    end
    // explicit corners: bctl via unaligned byte, exact-address read rule
    do_write('h73, 0, 32'h0000_005A);
    do_read('h70, 3);
    do_read('h73, 0);
    do_write('h6C, 3, 32'h1234_5678);
    do_read('h70, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule